// File: doc/BRIEF.md
# Address Break Comparator Channel

A debug watch unit that observes every cycle on a bus-monitor input and compares it against per-channel conditions. It has two identical channels. Each channel holds a byte-wide control word and a 24-bit break address. A bus cycle satisfies a channel when all three of these hold: its address agrees with the break address outside a masked group of low bits, its cycle type is the selected kind, and its bus master is allowed. On such a cycle the channel's sticky match flag is set.

Software reaches the control words and the address bytes through a small byte-wide register port. The match flag cannot be raised by software. Software can clear it only by first reading the control word while the flag shows 1 and then writing a 0 to the flag bit. Each channel has an enable bit that lets its flag drive a shared break interrupt request.

Top module: `brk_unit`

## Requirements
- R1: After reset, all eight register offsets read 0x00 and `irq` is 0.
- R2: Register offsets are: 0 is channel A control, 1 is channel B control, 2/3/4 are channel A address bits [7:0]/[15:8]/[23:16], and 5/6/7 are the same bytes for channel B. Control bits are [7] match flag, [6] any-master, [5:3] mask code, [2:1] cycle select and [0] interrupt enable. Bits [6:0] and the address bytes read back as written.
- R3: `bus_kind` encodes 00 fetch, 01 data read, 10 data write and 11 idle. Cycle select 00 matches fetch, 01 matches read, 10 matches write, and 11 matches read or write. Idle cycles never match.
- R4: When any-master is 0, only cycles with `bus_dma`=0 (CPU master) can match. When it is 1, cycles with either value of `bus_dma` can match.
- R5: Mask codes 0 to 7 leave 0, 1, 2, 3, 4, 8, 12 and 16 low address bits out of the compare. All higher bits must be equal.
- R6: A matching cycle with `bus_valid`=1 sets the flag. The flag reads as 1 from the next cycle on.
- R7: Writing 1 to the flag bit has no effect on the flag.
- R8: A write with bit 7 = 0 clears the flag only if the most recent access to that control register was a read that returned the flag as 1. Any write to that register removes this arming.
- R9: If a match and a valid clear happen in the same cycle, the flag stays 1.
- R10: `irq` is 1 exactly while some channel has its flag and its enable both 1. A set flag with enable 0 raises no request.
- R11: The channels are independent. Activity that matches only one channel leaves the other channel's register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of a read |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 24 | Bus cycle address |
| bus_kind | input | 2 | Bus cycle type |
| bus_dma | input | 1 | 1 = transfer controller is master, 0 = CPU |
| irq | output | 1 | Break interrupt request |

## Verification
The hardest state to reach is a clear write that lands in the same cycle as a matching bus cycle while the clear is armed. The stimulus gets there in three steps. It sets the flag, performs an arming read, and then drives the register write and the bus monitor together in a single cycle. Disarming is reached in a similar way. A read arms the clear, a flag-bit-1 write follows, and then a 0 write is shown to leave the flag in place. The mask ladder is covered by walking all eight codes, each with one address just above the masked field and one with every masked bit flipped.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_READ  = 2'b01,
        CYC_WRITE = 2'b10,
        CYC_IDLE  = 2'b11
    } cyc_e;

    typedef struct packed {
        logic       flag;
        logic       any_master;
        logic [2:0] mask_code;
        logic [1:0] cond;
        logic       ie;
    } ctl_t;

    // number of low address bits left out of the compare
    function automatic int mask_width(logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 3;
            3'd4:    return 4;
            3'd5:    return 8;
            3'd6:    return 12;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/brk_match.sv
module brk_match
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  cyc_e              bus_kind,
    input  logic              bus_dma,
    output logic              hit
);

    logic [ADDR_W-1:0] care;
    logic              kind_ok;
    logic              master_ok;
    logic              addr_ok;
    int                width;

    always_comb begin
        width = mask_width(ctl.mask_code);
        for (int i = 0; i < ADDR_W; i++) begin
            care[i] = (i >= width);
        end
    end

    always_comb begin
        case (ctl.cond)
            2'b00:   kind_ok = (bus_kind == CYC_FETCH);
            2'b01:   kind_ok = (bus_kind == CYC_READ);
            2'b10:   kind_ok = (bus_kind == CYC_WRITE);
            default: kind_ok = (bus_kind == CYC_READ) || (bus_kind == CYC_WRITE);
        endcase
    end

    assign master_ok = !bus_dma || ctl.any_master;
    assign addr_ok   = (((bus_addr ^ ref_addr) & care) == '0);
    assign hit       = bus_valid && kind_ok && master_ok && addr_ok;

endmodule

// File: rtl/brk_chan.sv
module brk_chan
    import brk_pkg::*;
#(
    parameter  int ADDR_W = 24,
    localparam int NBYTES = (ADDR_W + 7) / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [NBYTES-1:0] addr_wr,
    input  logic [7:0]        wdata,
    input  logic              hit,
    output ctl_t              ctl_q,
    output logic [ADDR_W-1:0] ref_addr_q
);

    typedef struct packed {
        ctl_t              ctl;
        logic              armed;
        logic [ADDR_W-1:0] addr;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [NBYTES*8-1:0] addr_wide;

    always_comb begin
        st_d = st_q;
        addr_wide = '0;
        addr_wide[ADDR_W-1:0] = st_q.addr;

        if (ctl_wr) begin
            st_d.ctl.any_master = wdata[6];
            st_d.ctl.mask_code  = wdata[5:3];
            st_d.ctl.cond       = wdata[2:1];
            st_d.ctl.ie         = wdata[0];
            if (!wdata[7] && st_q.armed) begin
                st_d.ctl.flag = 1'b0;
            end
            st_d.armed = 1'b0;
        end else if (ctl_rd && st_q.ctl.flag) begin
            st_d.armed = 1'b1;
        end

        for (int b = 0; b < NBYTES; b++) begin
            if (addr_wr[b]) begin
                addr_wide[b*8 +: 8] = wdata;
            end
        end
        st_d.addr = addr_wide[ADDR_W-1:0];

        // a bus match outranks a clear in the same cycle
        if (hit) begin
            st_d.ctl.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q      = st_q.ctl;
    assign ref_addr_q = st_q.addr;

endmodule

// File: rtl/brk_unit.sv
module brk_unit
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NCH    = 2,
    parameter int OFS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_kind,
    input  logic              bus_dma,
    output logic              irq
);

    localparam int NBYTES = (ADDR_W + 7) / 8;

    ctl_t              ctl_q   [NCH];
    logic [ADDR_W-1:0] ref_q   [NCH];
    logic [NCH-1:0]    flag_vec;
    logic [NCH-1:0]    ie_vec;
    logic              rd_acc;
    logic              wr_acc;
    cyc_e              kind;

    assign rd_acc = reg_en && !reg_wr;
    assign wr_acc = reg_en && reg_wr;
    assign kind   = cyc_e'(bus_kind);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic              sel_ctl;
        logic [NBYTES-1:0] sel_byte;
        logic              hit;

        assign sel_ctl = (reg_addr == OFS_W'(c));
        for (genvar j = 0; j < NBYTES; j++) begin : g_byte
            assign sel_byte[j] = wr_acc && (reg_addr == OFS_W'(NCH + c*NBYTES + j));
        end

        brk_match #(.ADDR_W(ADDR_W)) u_match (
            .ctl       (ctl_q[c]),
            .ref_addr  (ref_q[c]),
            .bus_valid (bus_valid),
            .bus_addr  (bus_addr),
            .bus_kind  (kind),
            .bus_dma   (bus_dma),
            .hit       (hit)
        );

        brk_chan #(.ADDR_W(ADDR_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctl_wr     (wr_acc && sel_ctl),
            .ctl_rd     (rd_acc && sel_ctl),
            .addr_wr    (sel_byte),
            .wdata      (reg_wdata),
            .hit        (hit),
            .ctl_q      (ctl_q[c]),
            .ref_addr_q (ref_q[c])
        );

        assign flag_vec[c] = ctl_q[c].flag;
        assign ie_vec[c]   = ctl_q[c].ie;
    end

    always_comb begin
        logic [NBYTES*8-1:0] wide;
        reg_rdata = '0;
        wide      = '0;
        if (rd_acc) begin
            for (int c = 0; c < NCH; c++) begin
                wide = '0;
                wide[ADDR_W-1:0] = ref_q[c];
                if (reg_addr == OFS_W'(c)) begin
                    reg_rdata = ctl_q[c];
                end
                for (int j = 0; j < NBYTES; j++) begin
                    if (reg_addr == OFS_W'(NCH + c*NBYTES + j)) begin
                        reg_rdata = wide[j*8 +: 8];
                    end
                end
            end
        end
    end

    assign irq = |(flag_vec & ie_vec);

endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_en,
    input logic           reg_wr,
    input logic           bus_valid,
    input logic [NCH-1:0] flag_vec,
    input logic           irq
);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R6: a flag rises only after a bus cycle was presented
        assert_set_needs_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_vec[c]) |-> $past(bus_valid));

        // R8: a flag falls only after a register write
        assert_clear_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_vec[c]) |-> $past(reg_en && reg_wr));
    end

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_vec != '0));

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && !(reg_en && reg_wr)) |=> $stable(irq));

endmodule

bind brk_unit brk_unit_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_wr    (reg_wr),
    .bus_valid (bus_valid),
    .flag_vec  (flag_vec),
    .irq       (irq)
);

// File: tb/sim_brk_unit.sv
`timescale 1ns/100ps
module sim_brk_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        bus_valid = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [1:0]  bus_kind = 2'b11;
    logic        bus_dma = 1'b0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    brk_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_kind(bus_kind),
        .bus_dma(bus_dma), .irq(irq)
    );

    // monitor: pops an expected byte for each read seen on the port
    always @(negedge clk) begin
        if (rst_n && reg_en && !reg_wr) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL read with no expectation: got %02h", reg_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    mismatched++;
                    $display("FAIL %s: read %02h expected %02h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(posedge clk); #1;
        reg_en = 1'b0;
    endtask

    task automatic bus(input logic [23:0] a, input logic [1:0] k, input logic m);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_addr = a; bus_kind = k; bus_dma = m;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_kind = 2'b11;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        compared++;
        if (irq !== e) begin
            mismatched++;
            $display("FAIL %s: irq %0b expected %0b", t, irq, e);
        end
    endtask

    function automatic int ladder(input int code);
        case (code)
            5: return 8;
            6: return 12;
            7: return 16;
            default: return code;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [23:0] base;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 reset");
        chk_irq(1'b0, "R1 reset irq");

        // R2 programming and readback of channel A
        wr(3'd2, 8'h56); wr(3'd3, 8'h34); wr(3'd4, 8'h12);
        wr(3'd0, 8'h01);
        rd(3'd2, 8'h56, "R2 addr A lo");
        rd(3'd3, 8'h34, "R2 addr A mid");
        rd(3'd4, 8'h12, "R2 addr A hi");
        rd(3'd0, 8'h01, "R2 ctl A");

        // R7 software cannot raise the flag
        wr(3'd0, 8'h81);
        rd(3'd0, 8'h01, "R7 write one");

        // R5 exact compare, R3 wrong kind, R4 wrong master
        bus(24'h123457, 2'b00, 1'b0);
        rd(3'd0, 8'h01, "R5 exact mismatch");
        bus(24'h123456, 2'b01, 1'b0);
        rd(3'd0, 8'h01, "R3 read vs fetch");
        bus(24'h123456, 2'b00, 1'b1);
        rd(3'd0, 8'h01, "R4 dma excluded");
        chk_irq(1'b0, "R10 no flag");

        // R6 set, R10 request
        bus(24'h123456, 2'b00, 1'b0);
        chk_irq(1'b1, "R10 flag and enable");
        rd(3'd0, 8'h81, "R6 flag set");

        // R8 armed clear
        wr(3'd0, 8'h01);
        rd(3'd0, 8'h01, "R8 armed clear");
        chk_irq(1'b0, "R10 cleared");

        // R8 unarmed clear ignored
        bus(24'h123456, 2'b00, 1'b0);
        wr(3'd0, 8'h01);
        rd(3'd0, 8'h81, "R8 unarmed clear");
        // R8 arming dropped by an intervening write
        wr(3'd0, 8'h81);
        wr(3'd0, 8'h01);
        rd(3'd0, 8'h81, "R8 disarmed by write");

        // R9 set wins over armed clear in the same cycle
        @(posedge clk); #1;
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h01;
        bus_valid = 1'b1; bus_addr = 24'h123456; bus_kind = 2'b00; bus_dma = 1'b0;
        @(posedge clk); #1;
        reg_en = 1'b0; reg_wr = 1'b0; bus_valid = 1'b0; bus_kind = 2'b11;
        rd(3'd0, 8'h81, "R9 set wins");
        wr(3'd0, 8'h01);
        rd(3'd0, 8'h01, "R8 clear after R9");

        // R4 any master accepts the transfer controller
        wr(3'd0, 8'h41);
        bus(24'h123456, 2'b00, 1'b1);
        rd(3'd0, 8'hC1, "R4 dma allowed");
        chk_irq(1'b1, "R10 dma hit");
        wr(3'd0, 8'h00);
        rd(3'd0, 8'h00, "R8 clear and disable");
        chk_irq(1'b0, "R10 quiet");

        // R5 mask ladder on channel B, enable off
        base = 24'h5A5A5A;
        wr(3'd5, 8'h5A); wr(3'd6, 8'h5A); wr(3'd7, 8'h5A);
        rd(3'd7, 8'h5A, "R2 addr B hi");
        for (int code = 0; code < 8; code++) begin
            logic [7:0] cv;
            int n;
            n = ladder(code);
            cv = {2'b00, 3'(code), 2'b10, 1'b0};
            wr(3'd1, cv);
            bus(base ^ (24'h1 << n), 2'b10, 1'b0);
            rd(3'd1, cv, $sformatf("R5 code %0d bit above", code));
            bus(base ^ ((24'h1 << n) - 24'h1), 2'b10, 1'b0);
            rd(3'd1, cv | 8'h80, $sformatf("R5 code %0d masked bits", code));
            chk_irq(1'b0, "R10 enable off");
            wr(3'd1, cv);
            rd(3'd1, cv, "R8 ladder clear");
        end

        // R3 select 11 matches reads and writes, not fetch or idle
        wr(3'd1, 8'h47);
        bus(base, 2'b01, 1'b1);
        rd(3'd1, 8'hC7, "R3 either read");
        chk_irq(1'b1, "R10 channel B");
        wr(3'd1, 8'h47);
        bus(base, 2'b10, 1'b0);
        rd(3'd1, 8'hC7, "R3 either write");
        wr(3'd1, 8'h47);
        bus(base, 2'b00, 1'b0);
        rd(3'd1, 8'h47, "R3 either no fetch");
        bus(base, 2'b11, 1'b0);
        rd(3'd1, 8'h47, "R3 idle");

        // R11 independence
        wr(3'd0, 8'h01);
        bus(24'h123456, 2'b00, 1'b0);
        rd(3'd1, 8'h47, "R11 B untouched");
        rd(3'd0, 8'h81, "R11 A set");
        chk_irq(1'b1, "R10 channel A");

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL scoreboard left %0d items", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule